// File: doc/BRIEF.md
# Conversion Sequence Status Tracker

This block sits beside a multi-channel conversion sequencer and keeps its status byte current. It holds three sticky flags and a result pointer. The first flag marks that a sequence has finished. The second marks that an extra trigger edge arrived while a sequence was still running. The third marks that a result slot was overwritten before its completion flag was cleared. The result pointer is 4 bits wide and selects which of the 16 result slots receives the conversion now in flight. The sequencer pulses `conv_done` once per conversion and `seq_end` once per sequence. The register interface delivers strobes for writes to the start register (`start_wr`), writes to any other control or compare register (`abort_wr`), writes to the status register (`stat_wr`) and reads of a result slot (`res_rd`).

A two-state machine follows the sequencer. It has two states. `SEQ_IDLE` means no sequence is running and is the state after reset. `SEQ_BUSY` means a sequence is in progress. There are three transitions. *start*, on `start_wr`, moves from either state to `SEQ_BUSY`. *finish*, on `seq_end`, moves to `SEQ_IDLE`. *abort*, on `abort_wr`, also moves to `SEQ_IDLE`. If *start* and *finish* or *abort* occur in the same cycle, *start* wins.

Trigger overruns are counted only in `SEQ_BUSY`. A registered rising-edge detector on `trig_in` supplies the trigger edges. In FIFO mode the pointer keeps advancing from one sequence to the next. Otherwise it returns to slot 0 whenever a sequence starts or finishes.

Top module: `adc_seq_status`

## Requirements
- R1: `status` carries the done flag in bit 7, the trigger overrun flag in bit 5, the result overrun flag in bit 4 and the pointer in bits 3..0. Bit 6 reads 0. `res_idx` equals the pointer.
- R2: A `seq_end` pulse sets the done flag on the next cycle, and does so again after every sequence.
- R3: The done flag clears after a `stat_wr` with data bit 7 set, or after `start_wr`. It also clears after `res_rd` when `afc_mode`=1. A `res_rd` with `afc_mode`=0 leaves it unchanged.
- R4: The trigger overrun flag sets when `edge_mode`=1, the machine is in `SEQ_BUSY` and `trig_in` rises. It does not set in `SEQ_IDLE`, and it does not set when `edge_mode`=0.
- R5: Each overrun flag clears after a `stat_wr` that has its own bit set (bit 5 or bit 4). Both overrun flags clear after `abort_wr` or `start_wr`.
- R6: On `conv_done`, the result overrun flag sets if `ccf_flags[res_idx]`=1.
- R7: Each `conv_done` advances the pointer by one, wrapping from 15 to 0.
- R8: With `fifo_mode`=0 the pointer becomes 0 after `start_wr` and after `seq_end`. With `fifo_mode`=1 a `seq_end` leaves it unchanged.
- R9: `start_wr` or `abort_wr` sets the pointer to 0 even when `fifo_mode`=1. This takes priority over `conv_done`.
- R10: Status writes never change the pointer bits.
- R11: When a flag's set event and its write-1 clear fall in the same cycle, the flag ends up set.
- R12: A synchronous `rst` returns the status byte and `res_idx` to 0 and the machine to `SEQ_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_mode | input | 1 | 1: pointer carries over between sequences |
| edge_mode | input | 1 | 1: trigger is edge sensitive, so overruns are counted |
| afc_mode | input | 1 | 1: a result read clears the done flag |
| start_wr | input | 1 | Write strobe for the start register |
| abort_wr | input | 1 | Write strobe for another control or compare register |
| seq_end | input | 1 | Sequence finished pulse |
| conv_done | input | 1 | One conversion finished pulse |
| trig_in | input | 1 | External trigger level |
| ccf_flags | input | 16 | Per-slot conversion-complete flags |
| stat_wr | input | 1 | Write strobe for the status register |
| stat_wdata | input | 8 | Status write data, where a 1 clears the matching flag |
| res_rd | input | 1 | Read strobe for a result slot |
| status | output | 8 | Status byte |
| res_idx | output | 4 | Slot for the current result |

## Verification
The two functions that collide are a flag's set event and its write-1 clear. One example is `seq_end` together with a status write of 0x80. Another is `conv_done` onto a slot whose flag is set, together with a write of 0x10. Directed cases place both in one cycle and expect the flag to stay set. Long random runs produce many more such coincidences, including cases where `start_wr` or `abort_wr` also lands in that cycle. A bench model built from the priority order in the requirements judges every cycle.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_t;

    localparam int STAT_W     = 8;
    localparam int DONE_BIT   = 7;
    localparam int TOVR_BIT   = 5;
    localparam int ROVR_BIT   = 4;
    localparam int PTR_FLD_W  = 4;
endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge (
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    output logic edge_o
);
    logic trig_q;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= trig_in;
    end

    assign edge_o = trig_in & ~trig_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_stat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_wr,
    input  logic abort_wr,
    input  logic seq_end,
    output logic busy
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start_wr) state_d = SEQ_BUSY;
            end
            SEQ_BUSY: begin
                if (start_wr)                  state_d = SEQ_BUSY;
                else if (abort_wr || seq_end)  state_d = SEQ_IDLE;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == SEQ_BUSY);
    end

    p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
        start_wr |=> busy);
    p_stop_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (!start_wr && (abort_wr || seq_end)) |=> !busy);
endmodule

// File: rtl/adc_conv_ptr.sv
module adc_conv_ptr #(
    parameter int NUM_RES = 16,
    localparam int PTR_W = $clog2(NUM_RES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_mode,
    input  logic             start_wr,
    input  logic             abort_wr,
    input  logic             seq_end,
    input  logic             conv_done,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(NUM_RES - 1);

    logic [PTR_W-1:0] ptr_q;
    logic             restart;
    logic             end_clear;

    assign restart   = start_wr | abort_wr;
    assign end_clear = seq_end & ~fifo_mode;

    always_ff @(posedge clk) begin
        if (rst)                ptr_q <= '0;
        else if (restart)       ptr_q <= '0;
        else if (end_clear)     ptr_q <= '0;
        else if (conv_done)     ptr_q <= (ptr_q == PTR_MAX) ? '0 : ptr_q + PTR_W'(1);
    end

    assign ptr = ptr_q;

    p_ptr_clr_r9: assert property (@(posedge clk) disable iff (rst)
        (start_wr || abort_wr) |=> (ptr == '0));
    p_ptr_end_r8: assert property (@(posedge clk) disable iff (rst)
        (seq_end && !fifo_mode) |=> (ptr == '0));
    p_ptr_step_r7: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !start_wr && !abort_wr && !(seq_end && !fifo_mode))
        |=> (ptr == (($past(ptr) == PTR_MAX) ? '0 : $past(ptr) + PTR_W'(1))));
    p_ptr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!conv_done && !start_wr && !abort_wr && !(seq_end && !fifo_mode))
        |=> $stable(ptr));
endmodule

// File: rtl/adc_stat_flags.sv
module adc_stat_flags (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic edge_mode,
    input  logic afc_mode,
    input  logic trig_edge,
    input  logic start_wr,
    input  logic abort_wr,
    input  logic seq_end,
    input  logic conv_done,
    input  logic ccf_hit,
    input  logic stat_wr,
    input  logic w1c_done,
    input  logic w1c_tovr,
    input  logic w1c_rovr,
    input  logic res_rd,
    output logic done_f,
    output logic tovr_f,
    output logic rovr_f
);
    logic done_clr, tovr_set, rovr_set, restart;

    assign restart  = start_wr | abort_wr;
    assign done_clr = (stat_wr & w1c_done) | (afc_mode & res_rd);
    assign tovr_set = edge_mode & busy & trig_edge;
    assign rovr_set = conv_done & ccf_hit;

    always_ff @(posedge clk) begin
        if (rst)                    done_f <= 1'b0;
        else if (start_wr)          done_f <= 1'b0;
        else if (seq_end)           done_f <= 1'b1;
        else if (done_clr)          done_f <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                    tovr_f <= 1'b0;
        else if (restart)           tovr_f <= 1'b0;
        else if (tovr_set)          tovr_f <= 1'b1;
        else if (stat_wr && w1c_tovr) tovr_f <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                    rovr_f <= 1'b0;
        else if (restart)           rovr_f <= 1'b0;
        else if (rovr_set)          rovr_f <= 1'b1;
        else if (stat_wr && w1c_rovr) rovr_f <= 1'b0;
    end

    p_done_set_r2: assert property (@(posedge clk) disable iff (rst)
        (seq_end && !start_wr) |=> done_f);
    p_done_start_r3: assert property (@(posedge clk) disable iff (rst)
        start_wr |=> !done_f);
    p_ovr_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (start_wr || abort_wr) |=> (!tovr_f && !rovr_f));
    p_tovr_source_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(tovr_f) |-> $past(busy && edge_mode && trig_edge));
    p_rovr_keep_r11: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && w1c_rovr && conv_done && ccf_hit && !start_wr && !abort_wr) |=> rovr_f);
endmodule

// File: rtl/adc_seq_status.sv
module adc_seq_status
    import adc_stat_pkg::*;
#(
    parameter int NUM_RES = 16,
    localparam int PTR_W = $clog2(NUM_RES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fifo_mode,
    input  logic               edge_mode,
    input  logic               afc_mode,
    input  logic               start_wr,
    input  logic               abort_wr,
    input  logic               seq_end,
    input  logic               conv_done,
    input  logic               trig_in,
    input  logic [NUM_RES-1:0] ccf_flags,
    input  logic               stat_wr,
    input  logic [STAT_W-1:0]  stat_wdata,
    input  logic               res_rd,
    output logic [STAT_W-1:0]  status,
    output logic [PTR_W-1:0]   res_idx
);
    logic                 busy, trig_edge;
    logic                 done_f, tovr_f, rovr_f;
    logic [PTR_W-1:0]     ptr;
    logic [PTR_FLD_W-1:0] ptr_fld;
    logic                 unused_wbits;

    assign unused_wbits = ^{stat_wdata[6], stat_wdata[3:0]};

    adc_trig_edge u_edge (
        .clk     (clk),
        .rst     (rst),
        .trig_in (trig_in),
        .edge_o  (trig_edge)
    );

    adc_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start_wr (start_wr),
        .abort_wr (abort_wr),
        .seq_end  (seq_end),
        .busy     (busy)
    );

    adc_conv_ptr #(.NUM_RES(NUM_RES)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .fifo_mode (fifo_mode),
        .start_wr  (start_wr),
        .abort_wr  (abort_wr),
        .seq_end   (seq_end),
        .conv_done (conv_done),
        .ptr       (ptr)
    );

    adc_stat_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .edge_mode (edge_mode),
        .afc_mode  (afc_mode),
        .trig_edge (trig_edge),
        .start_wr  (start_wr),
        .abort_wr  (abort_wr),
        .seq_end   (seq_end),
        .conv_done (conv_done),
        .ccf_hit   (ccf_flags[ptr]),
        .stat_wr   (stat_wr),
        .w1c_done  (stat_wdata[DONE_BIT]),
        .w1c_tovr  (stat_wdata[TOVR_BIT]),
        .w1c_rovr  (stat_wdata[ROVR_BIT]),
        .res_rd    (res_rd),
        .done_f    (done_f),
        .tovr_f    (tovr_f),
        .rovr_f    (rovr_f)
    );

    always_comb begin
        ptr_fld             = '0;
        ptr_fld[PTR_W-1:0]  = ptr;
        status              = '0;
        status[DONE_BIT]    = done_f;
        status[TOVR_BIT]    = tovr_f;
        status[ROVR_BIT]    = rovr_f;
        status[PTR_FLD_W-1:0] = ptr_fld;
        res_idx             = ptr;
    end

    p_bit6_zero_r1: assert property (@(posedge clk) disable iff (rst)
        status[6] == 1'b0);
    p_reset_clear_r12: assert property (@(posedge clk)
        rst |=> (status == '0));
endmodule

// File: tb/test_adc_seq_status.sv
`timescale 1ns/1ps
module test_adc_seq_status;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fifo_mode = 0, edge_mode = 0, afc_mode = 0;
    logic        start_wr = 0, abort_wr = 0, seq_end = 0, conv_done = 0;
    logic        trig_in = 0, stat_wr = 0, res_rd = 0;
    logic [15:0] ccf_flags = '0;
    logic [7:0]  stat_wdata = '0;
    logic [7:0]  status;
    logic [3:0]  res_idx;

    int n_chk = 0;
    int n_err = 0;

    logic       m_done = 0, m_tovr = 0, m_rovr = 0, m_busy = 0, m_trq = 0;
    logic [3:0] m_ptr = '0;

    always #4 clk = ~clk;

    adc_seq_status i_adc_seq_status (
        .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .edge_mode(edge_mode),
        .afc_mode(afc_mode), .start_wr(start_wr), .abort_wr(abort_wr),
        .seq_end(seq_end), .conv_done(conv_done), .trig_in(trig_in),
        .ccf_flags(ccf_flags), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .res_rd(res_rd), .status(status), .res_idx(res_idx)
    );

    function automatic logic [7:0] exp_status();
        return {m_done, 1'b0, m_tovr, m_rovr, m_ptr};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        logic edge_ev, n_busy, n_done, n_tovr, n_rovr;
        logic [3:0] n_ptr;
        @(posedge clk);
        edge_ev = trig_in && !m_trq;
        if (rst) begin
            n_busy = 0; n_done = 0; n_tovr = 0; n_rovr = 0; n_ptr = '0;
        end else begin
            n_busy = start_wr ? 1'b1 : ((abort_wr || seq_end) ? 1'b0 : m_busy);
            if (start_wr) n_done = 0;
            else if (seq_end) n_done = 1;
            else if ((stat_wr && stat_wdata[7]) || (afc_mode && res_rd)) n_done = 0;
            else n_done = m_done;
            if (start_wr || abort_wr) n_tovr = 0;
            else if (edge_mode && m_busy && edge_ev) n_tovr = 1;
            else if (stat_wr && stat_wdata[5]) n_tovr = 0;
            else n_tovr = m_tovr;
            if (start_wr || abort_wr) n_rovr = 0;
            else if (conv_done && ccf_flags[m_ptr]) n_rovr = 1;
            else if (stat_wr && stat_wdata[4]) n_rovr = 0;
            else n_rovr = m_rovr;
            if (start_wr || abort_wr) n_ptr = '0;
            else if (seq_end && !fifo_mode) n_ptr = '0;
            else if (conv_done) n_ptr = m_ptr + 4'd1;
            else n_ptr = m_ptr;
        end
        m_trq = rst ? 1'b0 : trig_in;
        m_busy = n_busy; m_done = n_done; m_tovr = n_tovr; m_rovr = n_rovr; m_ptr = n_ptr;
        @(negedge clk);
        start_wr = 0; abort_wr = 0; seq_end = 0; conv_done = 0;
        stat_wr = 0; res_rd = 0; stat_wdata = '0;
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        chk("R12 reset status", status, 8'h00);
        rst = 0;
        // R1 / R7: FIFO pointer advance and layout
        fifo_mode = 1; start_wr = 1; tick();
        chk("R9 start ptr", status, 8'h00);
        for (int i = 0; i < 3; i++) begin conv_done = 1; tick(); end
        chk("R7 advance", status, 8'h03);
        chk("R1 res_idx", {4'h0, res_idx}, 8'h03);
        seq_end = 1; tick();
        chk("R2/R8 fifo end keeps ptr", status, 8'h83);
        // R10 pointer bits ignored on write
        stat_wr = 1; stat_wdata = 8'h0F; tick();
        chk("R10 ptr write ignored", status, 8'h83);
        // R3 read clear only with afc_mode
        res_rd = 1; tick();
        chk("R3 read without afc", status, 8'h83);
        afc_mode = 1; res_rd = 1; tick();
        chk("R3 read with afc", status, 8'h03);
        afc_mode = 0;
        // R8 non-FIFO
        fifo_mode = 0; start_wr = 1; tick();
        chk("R8 start clears", status, 8'h00);
        conv_done = 1; tick(); conv_done = 1; tick();
        chk("R7 two steps", status, 8'h02);
        seq_end = 1; tick();
        chk("R8 end clears ptr", status, 8'h80);
        start_wr = 1; tick();
        chk("R3 start clears done", status, 8'h00);
        seq_end = 1; stat_wr = 1; stat_wdata = 8'h80; tick();
        chk("R11 set beats clear done", status, 8'h80);
        // R4 trigger overrun
        edge_mode = 1; trig_in = 1; tick();
        chk("R4 idle edge ignored", status, 8'h80);
        trig_in = 0; tick();
        start_wr = 1; tick();
        trig_in = 1; tick();
        chk("R4 busy edge sets", status, 8'h20);
        trig_in = 0; tick();
        stat_wr = 1; stat_wdata = 8'h20; tick();
        chk("R5 w1c tovr", status, 8'h00);
        edge_mode = 0; trig_in = 1; tick();
        chk("R4 level mode ignored", status, 8'h00);
        trig_in = 0; tick();
        // R6 result overrun
        ccf_flags = '1; conv_done = 1; tick();
        chk("R6 overrun sets", status, 8'h11);
        ccf_flags = '0; stat_wr = 1; stat_wdata = 8'h10; tick();
        chk("R5 w1c rovr", status, 8'h01);
        conv_done = 1; tick();
        chk("R6 no overrun", status, 8'h02);
        ccf_flags = 16'h0004; conv_done = 1; stat_wr = 1; stat_wdata = 8'h10; tick();
        chk("R11 set beats clear rovr", status, 8'h13);
        abort_wr = 1; tick();
        chk("R5/R9 abort", status, 8'h00);
        ccf_flags = '0;
        // R9 abort in FIFO mode, R7 wrap
        fifo_mode = 1; start_wr = 1; tick();
        for (int i = 0; i < 5; i++) begin conv_done = 1; tick(); end
        abort_wr = 1; conv_done = 1; tick();
        chk("R9 fifo abort", status, 8'h00);
        for (int i = 0; i < 16; i++) begin conv_done = 1; tick(); end
        chk("R7 wrap to 0", {4'h0, res_idx}, 8'h00);
        conv_done = 1; tick();
        chk("R7 after wrap", {4'h0, res_idx}, 8'h01);
        rst = 1; tick(); rst = 0;
        chk("R12 reset again", status, 8'h00);
        // random phase against the bench model
        void'($urandom(32'd7321));
        for (int c = 0; c < 4000; c++) begin
            start_wr   = ($urandom % 100) < 3;
            abort_wr   = ($urandom % 100) < 2;
            seq_end    = ($urandom % 100) < 6;
            conv_done  = ($urandom % 100) < 30;
            if (($urandom % 100) < 25) trig_in = ~trig_in;
            stat_wr    = ($urandom % 100) < 12;
            stat_wdata = 8'($urandom);
            res_rd     = ($urandom % 100) < 10;
            ccf_flags  = 16'($urandom);
            if (($urandom % 100) < 2) fifo_mode = ~fifo_mode;
            if (($urandom % 100) < 2) edge_mode = ~edge_mode;
            if (($urandom % 100) < 2) afc_mode  = ~afc_mode;
            tick();
            chk("R1 random status", status, exp_status());
            chk("R7 random res_idx", {4'h0, res_idx}, {4'h0, m_ptr});
        end
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule